// File: doc/BRIEF.md
# HDLC Bit-Level Receive Deframer

This block recovers HDLC frames from the raw octet stream of one 64 kbit/s bearer channel. Each accepted octet is serialised least significant bit first, one bit per clock. The bit stream then drives a four-state hunt machine: zero search, flag search, flag found and frame found. The machine finds opening and closing flags, removes stuffed zeros and packs the remaining data bits into bytes. It runs a CRC-16 over every completed byte.

Each completed byte is delivered on a byte strobe, and the first byte of a frame is marked. Every frame ends with exactly one strobe. A good-frame strobe carries the payload length. An error strobe carries a cause code and increments a wrapping error counter. The two FCS bytes are delivered as part of the byte stream, but the reported length leaves them out. A downstream buffer stores the bytes, then keeps or discards them depending on which end strobe arrives.

Top module: `hdlc_rx`

## Requirements
- R1: After reset the block is in zero search, all output strobes are low and the error counter is zero.
- R2: Input bits are taken LSB first from each octet, and each data bit enters the byte under construction from the MSB side. Each completed frame byte raises `byteValid` for one cycle, and `byteFirst` is high only with the first byte of a frame.
- R3: An input octet of 0xFF is not bit-processed. It returns the machine to zero search and clears the ones and bit counters. If a frame is open, that frame ends with `frameBad` and code 0 (abort).
- R4: A 1 bit that makes more than six consecutive ones returns the machine to zero search. Inside an open frame this ends the frame with `frameBad` and code 0 (abort).
- R5: A 0 bit that follows exactly five consecutive ones is discarded and is not part of the data.
- R6: A 0 bit that follows exactly six ones is a flag. After any frame end in which the closing flag is byte aligned, the machine is in flag-found, so one flag can close one frame and open the next.
- R7: The first byte completed after a flag opens a frame and starts the CRC from 0xFFFF, using the reflected polynomial 0x8408. At a byte-aligned closing flag, the frame is good when the CRC over all bytes, including both FCS bytes, equals 0xF0B8. `frameGood` then reports `frameLen` as the byte count minus two.
- R8: A byte-aligned closing flag with any other CRC value ends the frame with `frameBad` and code 3 (bad FCS).
- R9: A closing flag that arrives when the number of data bits is not a multiple of 8 ends the frame with `frameBad` and code 1 (misaligned). The machine then returns to flag search.
- R10: When a frame reaches MAX_BYTES bytes, that byte is not delivered. The frame ends with `frameBad` and code 2 (too long), and the machine returns to flag search. Frames of up to MAX_BYTES-1 bytes are accepted.
- R11: `errCount` increases by one, with wrap, in exactly the cycle in which `frameBad` is high.
- R12: Octets may arrive once every 8 clock cycles, and frames separated by a single flag at that rate are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| octValid | input | 1 | Raw channel octet present on octData |
| octData | input | 8 | Raw channel octet, first bit in bit 0 |
| byteValid | output | 1 | A recovered frame byte is on byteOut |
| byteOut | output | 8 | Recovered byte (payload or FCS) |
| byteFirst | output | 1 | byteOut is the first byte of a frame |
| frameGood | output | 1 | Frame ended with a correct FCS |
| frameBad | output | 1 | Frame ended in error, cause on errCode |
| errCode | output | 2 | 0 abort, 1 misaligned, 2 too long, 3 bad FCS |
| frameLen | output | $clog2(MAX_BYTES+1) | Payload length of the last good frame |
| errCount | output | ERR_W | Wrapping count of frame errors |

## Verification
The checker assumes that octets are at least 8 cycles apart, so that the serialiser has emptied before it is reloaded. Every bench octet is sent by a single task that waits out the full 8-cycle slot. The byte-spacing and end-strobe properties depend on that pacing, because a byte needs eight shifted bits. The stimulus builds every frame from its own stuffing and CRC, and closes each scenario with a 0xFF octet, so each case starts from zero search.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [1:0] {
    ST_ZERO = 2'd0,  // waiting for any 0 bit
    ST_HUNT = 2'd1,  // looking for a flag
    ST_OPEN = 2'd2,  // flag seen, no byte yet
    ST_BODY = 2'd3   // frame in progress
  } rxState_t;

  typedef enum logic [1:0] {
    ERR_ABORT = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_LONG  = 2'd2,
    ERR_FCS   = 2'd3
  } rxErr_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic   onesInc;
    logic   onesClr;
    logic   shiftBit;
    logic   cntClr;
    logic   valClr;
    logic   crcStart;
    logic   crcStep;
    logic   emitByte;
    logic   emitStart;
    logic   endGood;
    logic   endBad;
    rxErr_t errCode;
  } rxCtl_t;

endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int BIT_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             rxBit,
  input  logic             ffEvent,
  input  logic [2:0]       ones,
  input  logic [BIT_W-1:0] bitCnt,
  input  logic             crcOk,
  output rxCtl_t           ctl
);

  localparam logic [BIT_W:0] FULL_BITS = (BIT_W+1)'(MAX_BYTES * 8);

  rxState_t state, nxt;
  logic     completes, tooLong, sevenOnes;

  always_comb begin
    ctl       = '0;
    nxt       = state;
    completes = (bitCnt[2:0] == 3'd7);
    tooLong   = ({1'b0, bitCnt} + (BIT_W+1)'(1)) >= FULL_BITS;
    sevenOnes = rxBit && (ones >= 3'd6);
    if (ffEvent) begin
      ctl.onesClr = 1'b1;
      ctl.cntClr  = 1'b1;
      nxt         = ST_ZERO;
      if (state == ST_BODY) begin
        ctl.endBad  = 1'b1;
        ctl.errCode = ERR_ABORT;
      end
    end else if (bitValid) begin
      if (rxBit) ctl.onesInc = 1'b1;
      else       ctl.onesClr = 1'b1;
      case (state)
        ST_ZERO: if (!rxBit) nxt = ST_HUNT;
        ST_HUNT: begin
          if (sevenOnes) nxt = ST_ZERO;
          else if (!rxBit && ones == 3'd6) begin
            ctl.cntClr = 1'b1;
            ctl.valClr = 1'b1;
            nxt        = ST_OPEN;
          end
        end
        default: begin
          if (sevenOnes) begin
            nxt = ST_ZERO;
            if (state == ST_BODY) begin
              ctl.cntClr  = 1'b1;
              ctl.endBad  = 1'b1;
              ctl.errCode = ERR_ABORT;
            end
          end else if (!rxBit && ones == 3'd6) begin
            ctl.cntClr = 1'b1;
            ctl.valClr = 1'b1;
            if (state == ST_BODY) begin
              if (!completes) begin
                ctl.endBad  = 1'b1;
                ctl.errCode = ERR_ALIGN;
                nxt         = ST_HUNT;
              end else begin
                ctl.endGood = crcOk;
                ctl.endBad  = !crcOk;
                ctl.errCode = ERR_FCS;
                nxt         = ST_OPEN;
              end
            end
          end else if (!rxBit && ones == 3'd5) begin
            // stuffed zero: dropped
          end else begin
            ctl.shiftBit = 1'b1;
            if (completes) begin
              if (state == ST_OPEN) begin
                ctl.crcStart  = 1'b1;
                ctl.emitByte  = 1'b1;
                ctl.emitStart = 1'b1;
                nxt           = ST_BODY;
              end else if (tooLong) begin
                ctl.endBad  = 1'b1;
                ctl.errCode = ERR_LONG;
                ctl.valClr  = 1'b1;
                nxt         = ST_HUNT;
              end else begin
                ctl.crcStep  = 1'b1;
                ctl.emitByte = 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ZERO;
    else       state <= nxt;
  end

endmodule

// File: rtl/hdlc_rx_dp.sv
module hdlc_rx_dp
  import hdlc_rx_pkg::*;
#(
  parameter int BIT_W = 10,
  parameter int LEN_W = 7,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             octValid,
  input  logic [7:0]       octData,
  input  rxCtl_t           ctl,
  output logic             bitValid,
  output logic             rxBit,
  output logic             ffEvent,
  output logic [2:0]       ones,
  output logic [BIT_W-1:0] bitCnt,
  output logic             crcOk,
  output logic             byteValid,
  output logic [7:0]       byteOut,
  output logic             byteFirst,
  output logic             frameGood,
  output logic             frameBad,
  output logic [1:0]       errCode,
  output logic [LEN_W-1:0] frameLen,
  output logic [ERR_W-1:0] errCount
);

  localparam logic [15:0] CRC_POLY = 16'h8408;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;

  function automatic logic [15:0] crcNext(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [7:0]       feedSh;
  logic [3:0]       feedLeft;
  logic             ffPend;
  logic [7:0]       rVal;
  logic [15:0]      crc;
  logic [7:0]       newByte;
  logic [BIT_W-1:0] byteTotal;
  logic             ffIn;

  assign ffIn      = octValid && (octData == 8'hFF);
  assign bitValid  = (feedLeft != 4'd0);
  assign rxBit     = feedSh[0];
  assign ffEvent   = ffPend && !bitValid;
  assign newByte   = {rxBit, rVal[7:1]};
  assign crcOk     = (crc == CRC_GOOD);
  assign byteTotal = (bitCnt + BIT_W'(1)) >> 3;

  // octet serialiser
  always_ff @(posedge clk) begin
    if (!rstN) begin
      feedSh   <= '0;
      feedLeft <= '0;
      ffPend   <= 1'b0;
    end else begin
      if (octValid && !ffIn) begin
        feedSh   <= octData;
        feedLeft <= 4'd8;
      end else if (bitValid) begin
        feedSh   <= feedSh >> 1;
        feedLeft <= feedLeft - 4'd1;
      end
      if (ffIn)         ffPend <= 1'b1;
      else if (ffEvent) ffPend <= 1'b0;
    end
  end

  // bit accumulation and CRC
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ones   <= '0;
      bitCnt <= '0;
      rVal   <= '0;
      crc    <= 16'hFFFF;
    end else begin
      if (ctl.onesClr)                ones <= '0;
      else if (ctl.onesInc && ones != 3'd7) ones <= ones + 3'd1;
      if (ctl.cntClr)        bitCnt <= '0;
      else if (ctl.shiftBit) bitCnt <= bitCnt + BIT_W'(1);
      if (ctl.valClr)        rVal <= '0;
      else if (ctl.shiftBit) rVal <= newByte;
      if (ctl.crcStart)      crc <= crcNext(16'hFFFF, newByte);
      else if (ctl.crcStep)  crc <= crcNext(crc, newByte);
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      byteOut   <= '0;
      byteFirst <= 1'b0;
      frameGood <= 1'b0;
      frameBad  <= 1'b0;
      errCode   <= '0;
      frameLen  <= '0;
      errCount  <= '0;
    end else begin
      byteValid <= ctl.emitByte;
      byteFirst <= ctl.emitStart;
      frameGood <= ctl.endGood;
      frameBad  <= ctl.endBad;
      if (ctl.emitByte) byteOut <= newByte;
      if (ctl.endGood)  frameLen <= LEN_W'(byteTotal - BIT_W'(3));
      if (ctl.endBad) begin
        errCode  <= ctl.errCode;
        errCount <= errCount + ERR_W'(1);
      end
    end
  end

endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
  import hdlc_rx_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int ERR_W     = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           octValid,
  input  logic [7:0]                     octData,
  output logic                           byteValid,
  output logic [7:0]                     byteOut,
  output logic                           byteFirst,
  output logic                           frameGood,
  output logic                           frameBad,
  output logic [1:0]                     errCode,
  output logic [$clog2(MAX_BYTES+1)-1:0] frameLen,
  output logic [ERR_W-1:0]               errCount
);

  localparam int BIT_W = $clog2(MAX_BYTES * 8 + 16);
  localparam int LEN_W = $clog2(MAX_BYTES + 1);

  rxCtl_t           ctl;
  logic             bitValid, rxBit, ffEvent, crcOk;
  logic [2:0]       ones;
  logic [BIT_W-1:0] bitCnt;

  hdlc_rx_ctrl #(.MAX_BYTES(MAX_BYTES), .BIT_W(BIT_W)) uCtl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .ffEvent(ffEvent), .ones(ones), .bitCnt(bitCnt), .crcOk(crcOk),
    .ctl(ctl)
  );

  hdlc_rx_dp #(.BIT_W(BIT_W), .LEN_W(LEN_W), .ERR_W(ERR_W)) uDp (
    .clk(clk), .rstN(rstN), .octValid(octValid), .octData(octData),
    .ctl(ctl), .bitValid(bitValid), .rxBit(rxBit), .ffEvent(ffEvent),
    .ones(ones), .bitCnt(bitCnt), .crcOk(crcOk),
    .byteValid(byteValid), .byteOut(byteOut), .byteFirst(byteFirst),
    .frameGood(frameGood), .frameBad(frameBad), .errCode(errCode),
    .frameLen(frameLen), .errCount(errCount)
  );

endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker #(
  parameter int MAX_BYTES = 64,
  parameter int ERR_W     = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           octValid,
  input logic                           byteValid,
  input logic                           byteFirst,
  input logic                           frameGood,
  input logic                           frameBad,
  input logic [$clog2(MAX_BYTES+1)-1:0] frameLen,
  input logic [ERR_W-1:0]               errCount
);

  localparam int LEN_W = $clog2(MAX_BYTES + 1);

  logic [3:0] gap;

  always_ff @(posedge clk) begin
    if (!rstN)         gap <= 4'd8;
    else if (octValid) gap <= 4'd1;
    else if (gap != 4'd8) gap <= gap + 4'd1;
  end

  // input pacing taken for granted (R12)
  assert_octet_gap_R12: assert property (@(posedge clk) disable iff (!rstN)
    octValid |-> gap == 4'd8);

  assert_err_inc_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameBad |-> errCount == $past(errCount) + ERR_W'(1));

  assert_end_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(frameGood && frameBad));

  assert_first_with_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    byteFirst |-> byteValid);

  assert_byte_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameGood |-> frameLen <= LEN_W'(MAX_BYTES - 3));

endmodule

bind hdlc_rx hdlc_rx_checker #(.MAX_BYTES(MAX_BYTES), .ERR_W(ERR_W)) uChk (
  .clk(clk), .rstN(rstN), .octValid(octValid), .byteValid(byteValid),
  .byteFirst(byteFirst), .frameGood(frameGood), .frameBad(frameBad),
  .frameLen(frameLen), .errCount(errCount)
);

// File: tb/hdlc_rx_bench.sv
`timescale 1ns/1ps
module hdlc_rx_bench;

  localparam int MAXB = 64;
  localparam int NV   = 10;

  typedef struct packed {
    logic [7:0] len;
    logic [2:0] kind;  // 0 good,1 bad fcs,2 misaligned,3 seven ones,4 0xFF abort,5 too long
    logic [7:0] seed;
    logic [7:0] fill;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'd4,        3'd0, 8'h11, 8'h00},
    '{8'd3,        3'd0, 8'h00, 8'hFF},
    '{8'd5,        3'd0, 8'h00, 8'h7E},
    '{8'd1,        3'd0, 8'hA5, 8'h00},
    '{8'd6,        3'd1, 8'h3C, 8'h00},
    '{8'd4,        3'd2, 8'h5A, 8'h00},
    '{8'd4,        3'd3, 8'hC3, 8'h00},
    '{8'd4,        3'd4, 8'h96, 8'h00},
    '{8'(MAXB-3),  3'd0, 8'h21, 8'h00},
    '{8'(MAXB-2),  3'd5, 8'h42, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       octValid = 1'b0;
  logic [7:0] octData = 8'h00;
  logic       byteValid, byteFirst, frameGood, frameBad;
  logic [7:0] byteOut;
  logic [1:0] errCode;
  logic [6:0] frameLen;
  logic [7:0] errCount;

  always #4 clk = ~clk;

  hdlc_rx #(.MAX_BYTES(MAXB), .ERR_W(8)) u_hdlc_rx (
    .clk(clk), .rstN(rstN), .octValid(octValid), .octData(octData),
    .byteValid(byteValid), .byteOut(byteOut), .byteFirst(byteFirst),
    .frameGood(frameGood), .frameBad(frameBad), .errCode(errCode),
    .frameLen(frameLen), .errCount(errCount)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] gotB[$];
  bit         gotF[$];
  int         goodLens[$];
  int         errCodes[$];
  bit         bq[$];
  logic [7:0] pay[$];
  int         stuffOnes;

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        gotB.push_back(byteOut);
        gotF.push_back(byteFirst);
      end
      if (frameGood) goodLens.push_back(int'(frameLen));
      if (frameBad)  errCodes.push_back(int'(errCode));
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finishRun();
    end
  end

  function automatic logic [15:0] crcOf();
    logic [15:0] c = 16'hFFFF;
    foreach (pay[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ pay[k][i]) c = (c >> 1) ^ 16'h8408;
        else                  c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic pushRaw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bq.push_back(b[i]);
  endtask

  task automatic pushFlag();
    pushRaw(8'h7E);
    stuffOnes = 0;
  endtask

  task automatic pushStuffed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      bq.push_back(b[i]);
      if (b[i]) begin
        stuffOnes++;
        if (stuffOnes == 5) begin
          bq.push_back(1'b0);
          stuffOnes = 0;
        end
      end else stuffOnes = 0;
    end
  endtask

  task automatic sendOctet(input logic [7:0] b);
    @(posedge clk); #1;
    octValid = 1'b1;
    octData  = b;
    @(posedge clk); #1;
    octValid = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic flush(input bit padBit);
    logic [7:0] o;
    while (bq.size() % 8 != 0) bq.push_back(padBit);
    while (bq.size() != 0) begin
      for (int i = 0; i < 8; i++) o[i] = bq.pop_front();
      sendOctet(o);
    end
  endtask

  task automatic endScenario();
    sendOctet(8'hFF);
    repeat (16) @(posedge clk);
  endtask

  task automatic clearObs();
    gotB.delete(); gotF.delete(); goodLens.delete(); errCodes.delete();
  endtask

  task automatic runVector(input vec_t v);
    logic [15:0] fcs;
    logic [7:0]  prevErr;
    int          len, bad, firsts, expCode;
    string       req;
    len = int'(v.len);
    clearObs();
    prevErr = errCount;
    pay.delete();
    for (int i = 0; i < len; i++)
      pay.push_back((v.fill != 8'h00) ? v.fill : (v.seed ^ 8'(i * 37)));
    fcs = ~crcOf();
    if (v.kind == 3'd1) fcs = fcs ^ 16'h0001;
    pushFlag();
    if (v.kind == 3'd3 || v.kind == 3'd4) begin
      pushStuffed(pay[0]);
      pushStuffed(pay[1]);
      if (v.kind == 3'd3) begin
        for (int i = 0; i < 7; i++) bq.push_back(1'b1);
        flush(1'b1);
      end else flush(1'b0);
    end else begin
      foreach (pay[k]) pushStuffed(pay[k]);
      pushStuffed(fcs[7:0]);
      pushStuffed(fcs[15:8]);
      if (v.kind == 3'd2) begin
        for (int i = 0; i < 3; i++) bq.push_back(1'b0);
      end
      pushFlag();
      flush(1'b1);
    end
    endScenario();

    if (v.kind == 3'd0) begin
      // R5 when the fill forces stuffing, R7 for the residue and length
      req = (v.fill == 8'hFF || v.fill == 8'h7E) ? "R5" : "R2";
      check(gotB.size() == len + 2, req, "byte count", gotB.size(), len + 2);
      bad = 0;
      for (int i = 0; i < len + 2 && i < gotB.size(); i++) begin
        logic [7:0] e;
        e = (i < len) ? pay[i] : ((i == len) ? fcs[7:0] : fcs[15:8]);
        if (gotB[i] !== e) bad++;
      end
      check(bad == 0, req, "byte mismatches", bad, 0);
      firsts = 0;
      foreach (gotF[k]) firsts += int'(gotF[k]);
      check(gotF.size() > 0 && gotF[0] && firsts == 1, "R2", "first marker count", firsts, 1);
      check(goodLens.size() == 1, "R7", "good strobes", goodLens.size(), 1);
      if (goodLens.size() == 1)
        check(goodLens[0] == len, "R7", "frame length", goodLens[0], len);
      check(errCodes.size() == 0, "R6", "error strobes", errCodes.size(), 0);
    end else begin
      case (v.kind)
        3'd1: begin req = "R8";  expCode = 3; end
        3'd2: begin req = "R9";  expCode = 1; end
        3'd3: begin req = "R4";  expCode = 0; end
        3'd4: begin req = "R3";  expCode = 0; end
        default: begin req = "R10"; expCode = 2; end
      endcase
      check(errCodes.size() == 1, req, "error strobes", errCodes.size(), 1);
      if (errCodes.size() == 1)
        check(errCodes[0] == expCode, req, "error code", errCodes[0], expCode);
      check(goodLens.size() == 0, req, "good strobes", goodLens.size(), 0);
      check(errCount == prevErr + 8'd1, "R11", "error counter",
            int'(errCount), int'(prevErr + 8'd1));
      if (v.kind == 3'd5)
        check(gotB.size() == MAXB - 1, "R10", "bytes before overflow", gotB.size(), MAXB - 1);
    end
  endtask

  task automatic sharedFlag();
    logic [15:0] f;
    clearObs();
    pushFlag();
    pay.delete(); pay.push_back(8'h3F); pay.push_back(8'hF8);
    f = ~crcOf();
    foreach (pay[k]) pushStuffed(pay[k]);
    pushStuffed(f[7:0]); pushStuffed(f[15:8]);
    pushFlag();
    pay.delete(); pay.push_back(8'h01); pay.push_back(8'hFE); pay.push_back(8'h7E);
    f = ~crcOf();
    foreach (pay[k]) pushStuffed(pay[k]);
    pushStuffed(f[7:0]); pushStuffed(f[15:8]);
    pushFlag();
    flush(1'b1);
    endScenario();
    check(goodLens.size() == 2, "R6", "frames on shared flag", goodLens.size(), 2);
    if (goodLens.size() == 2) begin
      check(goodLens[0] == 2, "R12", "first length", goodLens[0], 2);
      check(goodLens[1] == 3, "R12", "second length", goodLens[1], 3);
    end
    check(errCodes.size() == 0, "R6", "error strobes", errCodes.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!byteValid && !frameGood && !frameBad, "R1", "strobes after reset",
          int'({byteValid, frameGood, frameBad}), 0);
    check(errCount == 8'd0, "R1", "error counter after reset", int'(errCount), 0);
    for (int n = 0; n < NV; n++) runVector(VEC[n]);
    sharedFlag();
    done = 1;
    finishRun();
  end

endmodule